// File: doc/BRIEF.md
# Two-way lockable write-back data cache

This block is a data cache controller placed between a processor load/store port and a memory port that moves whole lines. Each set holds two ways of 64-byte lines. A lookup compares the tags of both ways of the indexed set. A hit is served from the line. A miss picks a victim way, writes that victim back if it holds modified data, then fills the line and serves the access from the refilled line. Stores allocate on a miss.

The victim is picked from one replacement bit per way: the two bits are combined by exclusive-or, and a lock bit on the chosen way redirects the choice to the other way. A maintenance operation writes a tag and all flag bits directly into a way picked by index. Every access also carries a flag that says whether its physical frame exists. A line filled for a missing frame reads as zeros, and when it is evicted its data is dropped without a memory write.

Top module: `dcache_ctrl`

## Requirements
- R1: Reset clears every valid, dirty, lock and replacement bit. After reset `req_ready` is 1, `resp_valid` is 0 and no memory request is raised. The first line filled into any set goes to way 0.
- R2: A load or store miss with `req_frame_ok`=1 issues exactly one fill request, at the access address with its low 6 bits cleared. A hit issues no memory request of either kind.
- R3: `req_size` gives the access width: 0=1, 1=2, 2=4, 3=8, 4=16 bytes. Accesses are naturally aligned. A load returns the bytes starting at line offset `req_addr[5:0]`, lowest address in `resp_rdata[7:0]`, with all bits above the access width at zero.
- R4: A store (`req_op`=1) replaces only the addressed bytes, taken from the low bits of `req_wdata`, and marks the line dirty. Later loads see the merged bytes, and an eviction writes back the whole merged line.
- R5: On a miss the candidate way is (replacement bit of way 0) XOR (replacement bit of way 1). The fill toggles the replacement bit of the way it fills.
- R6: A victim that is valid and dirty, and whose frame exists, is written back before the fill request is raised. The writeback address is made from the victim's stored tag and the set index. A clean or invalid victim causes no writeback. A fill request and a writeback request are never raised together.
- R7: If the candidate way is locked, the other way is replaced. If both ways are locked, the other way is still the one replaced, and `lock_err` is 1 in the cycle of that access's response.
- R8: A miss with `req_frame_ok`=0 raises no fill request and fills the line with zeros. When that line is later evicted dirty, no writeback is issued.
- R9: Operation `req_op`=2 writes one tag entry. The set comes from the address index bits, the way from `req_addr[0]`, and the tag from `req_wdata` at the address tag bit positions. The flags come from `req_wdata` bit 3 (valid), bit 2 (dirty), bit 1 (lock) and bit 0 (replacement). The operation answers with a response and causes no memory traffic. A valid entry written this way then hits.
- R10: A raised fill or writeback request holds its address, and for a writeback its data, until the cycle in which ready is seen.
- R11: `lock_err` stays 0 for every access that does not find both ways of its set locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Controller can accept a request |
| req_op | input | 2 | 0 load, 1 store, 2 tag write |
| req_size | input | 3 | Access width code |
| req_addr | input | ADDR_W | Physical byte address |
| req_wdata | input | CPU_W | Store data, or tag and flags for a tag write |
| req_frame_ok | input | 1 | Physical frame of this access exists |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_rdata | output | CPU_W | Load data |
| lock_err | output | 1 | Both ways were locked on this access's miss |
| mem_rd_valid | output | 1 | Fill request |
| mem_rd_ready | input | 1 | Fill request taken |
| mem_rd_addr | output | ADDR_W | Line-aligned fill address |
| mem_fill_valid | input | 1 | Fill data present |
| mem_fill_data | input | LINE_W | Fill line |
| mem_wr_valid | output | 1 | Writeback request |
| mem_wr_ready | input | 1 | Writeback taken |
| mem_wr_addr | output | ADDR_W | Line-aligned writeback address |
| mem_wr_data | output | LINE_W | Writeback line |

## Verification
The properties assume that the memory side returns exactly one fill pulse for each accepted fill request, and only after that request was taken. They also assume that processor accesses are naturally aligned to their width. The bench memory model asserts ready one cycle after each request and returns the fill two cycles after the handshake. Every access the bench issues sits at an offset that is a multiple of its width, so the stimulus stays inside these assumptions. Tag writes are used only to set up lock and dirty states on purpose, and their tags never alias a line already resident in the other way.

// File: rtl/dcache_pkg.sv
package dcache_pkg;
  typedef struct packed {
    logic nofr;
    logic valid;
    logic dirty;
    logic lock;
    logic lrf;
  } flags_t;

  localparam int FB_LRF   = 0;
  localparam int FB_LOCK  = 1;
  localparam int FB_DIRTY = 2;
  localparam int FB_VALID = 3;

  localparam logic [1:0] OP_LOAD   = 2'd0;
  localparam logic [1:0] OP_STORE  = 2'd1;
  localparam logic [1:0] OP_TAGSET = 2'd2;

  typedef enum logic [2:0] {
    S_IDLE, S_LOOK, S_WB, S_FILL, S_FREQ, S_FWAIT, S_REREAD
  } state_e;
endpackage

// File: rtl/dcache_tag_store.sv
module dcache_tag_store
  import dcache_pkg::*;
#(
  parameter int SETS  = 64,
  parameter int TAG_W = 20,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [IDX_W-1:0]      rd_set,
  output logic [1:0][TAG_W-1:0] rd_tag,
  output flags_t [1:0]          rd_flg,
  input  logic                  we,
  input  logic                  wr_way,
  input  logic [IDX_W-1:0]      wr_set,
  input  logic [TAG_W-1:0]      wr_tag,
  input  flags_t                wr_flg
);
  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [TAG_W-1:0] tag_q [SETS];
    flags_t           flg_q [SETS];
    logic             sel;
    assign sel = we && (wr_way == 1'(w));

    always_ff @(posedge clk) begin
      if (sel) tag_q[wr_set] <= wr_tag;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        for (int i = 0; i < SETS; i++) flg_q[i] <= '0;
      end else if (sel) begin
        flg_q[wr_set] <= wr_flg;
      end
    end

    assign rd_tag[w] = tag_q[rd_set];
    assign rd_flg[w] = flg_q[rd_set];
  end
endmodule

// File: rtl/dcache_data_store.sv
module dcache_data_store #(
  parameter int SETS   = 64,
  parameter int LINE_W = 512,
  localparam int IDX_W = $clog2(SETS),
  localparam int BE_W  = LINE_W / 8
) (
  input  logic                   clk,
  input  logic                   rd_en,
  input  logic [IDX_W-1:0]       rd_set,
  output logic [1:0][LINE_W-1:0] rd_line,
  input  logic [1:0]             wr_en,
  input  logic [IDX_W-1:0]       wr_set,
  input  logic [LINE_W-1:0]      wr_data,
  input  logic [BE_W-1:0]        wr_be
);
  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [LINE_W-1:0] mem [SETS];
    logic [LINE_W-1:0] q;

    always_ff @(posedge clk) begin
      if (wr_en[w]) begin
        for (int b = 0; b < BE_W; b++)
          if (wr_be[b]) mem[wr_set][b*8 +: 8] <= wr_data[b*8 +: 8];
      end
      if (rd_en) q <= mem[rd_set];
    end

    assign rd_line[w] = q;
  end
endmodule

// File: rtl/dcache_victim.sv
module dcache_victim
  import dcache_pkg::*;
(
  input  flags_t [1:0] flg,
  output logic         way,
  output logic         both_locked
);
  logic pick;
  assign pick        = flg[0].lrf ^ flg[1].lrf;
  assign way         = flg[pick].lock ? ~pick : pick;
  assign both_locked = flg[0].lock & flg[1].lock;
endmodule

// File: rtl/dcache_ctrl.sv
module dcache_ctrl
  import dcache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SETS       = 64,
  parameter int LINE_BYTES = 64,
  parameter int CPU_W      = 128,
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int IDX_W  = $clog2(SETS),
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W,
  localparam int LINE_W = LINE_BYTES * 8,
  localparam int CPU_B  = CPU_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [2:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CPU_W-1:0]  req_wdata,
  input  logic              req_frame_ok,
  output logic              resp_valid,
  output logic [CPU_W-1:0]  resp_rdata,
  output logic              lock_err,
  output logic              mem_rd_valid,
  input  logic              mem_rd_ready,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_fill_valid,
  input  logic [LINE_W-1:0] mem_fill_data,
  output logic              mem_wr_valid,
  input  logic              mem_wr_ready,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [LINE_W-1:0] mem_wr_data
);
  state_e             st;
  logic [1:0]         op_q;
  logic [2:0]         sz_q;
  logic [ADDR_W-1:0]  a_q;
  logic [CPU_W-1:0]   wd_q;
  logic               fo_q, vw_q, lerr_q;

  logic [IDX_W-1:0]   idx_q;
  logic [TAG_W-1:0]   tagf;
  logic [OFF_W-1:0]   off_q;
  assign idx_q = a_q[OFF_W +: IDX_W];
  assign tagf  = a_q[ADDR_W-1 -: TAG_W];
  assign off_q = a_q[OFF_W-1:0];

  logic [1:0][TAG_W-1:0]  rd_tag;
  flags_t [1:0]           rd_flg;
  logic [1:0][LINE_W-1:0] rd_line;
  logic                   tw_en, tw_way;
  logic [TAG_W-1:0]       tw_tag;
  flags_t                 tw_flg;
  logic [1:0]             dw_en;
  logic [LINE_W-1:0]      dw_data;
  logic [LINE_BYTES-1:0]  dw_be;
  logic                   rd_en;
  logic [IDX_W-1:0]       rd_set;
  logic                   vic_way, vic_both;

  assign req_ready = (st == S_IDLE);
  assign rd_en     = (st == S_IDLE && req_valid) || st == S_REREAD;
  assign rd_set    = (st == S_IDLE) ? req_addr[OFF_W +: IDX_W] : idx_q;

  dcache_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) i_tags (
    .clk(clk), .rst(rst), .rd_set(idx_q), .rd_tag(rd_tag), .rd_flg(rd_flg),
    .we(tw_en), .wr_way(tw_way), .wr_set(idx_q), .wr_tag(tw_tag), .wr_flg(tw_flg)
  );

  dcache_data_store #(.SETS(SETS), .LINE_W(LINE_W)) i_data (
    .clk(clk), .rd_en(rd_en), .rd_set(rd_set), .rd_line(rd_line),
    .wr_en(dw_en), .wr_set(idx_q), .wr_data(dw_data), .wr_be(dw_be)
  );

  dcache_victim i_victim (.flg(rd_flg), .way(vic_way), .both_locked(vic_both));

  logic hit0, hit1, hit, hw;
  assign hit0 = rd_flg[0].valid && (rd_tag[0] == tagf);
  assign hit1 = rd_flg[1].valid && (rd_tag[1] == tagf);
  assign hit  = hit0 | hit1;
  assign hw   = hit1;

  int                    nbytes;
  logic [LINE_BYTES-1:0] be_st;
  logic [LINE_W-1:0]     wline_st, ld_sh;
  logic [CPU_W-1:0]      ld_data;

  always_comb begin
    nbytes   = (sz_q >= 3'd4) ? CPU_B : (1 << sz_q);
    wline_st = LINE_W'(wd_q) << {off_q, 3'b000};
    ld_sh    = rd_line[hw] >> {off_q, 3'b000};
    for (int b = 0; b < LINE_BYTES; b++)
      be_st[b] = (b >= int'(off_q)) && (b < int'(off_q) + nbytes);
    ld_data = '0;
    for (int b = 0; b < CPU_B; b++)
      if (b < nbytes) ld_data[b*8 +: 8] = ld_sh[b*8 +: 8];
  end

  logic fill_wr;
  assign fill_wr = (st == S_FILL && !fo_q) || (st == S_FWAIT && mem_fill_valid);

  always_comb begin
    tw_en   = 1'b0;
    tw_way  = hw;
    tw_tag  = tagf;
    tw_flg  = rd_flg[hw];
    dw_en   = 2'b00;
    dw_be   = '1;
    dw_data = fo_q ? mem_fill_data : '0;
    if (st == S_LOOK && op_q == OP_TAGSET) begin
      tw_en        = 1'b1;
      tw_way       = a_q[0];
      tw_tag       = wd_q[ADDR_W-1 -: TAG_W];
      tw_flg.nofr  = 1'b0;
      tw_flg.valid = wd_q[FB_VALID];
      tw_flg.dirty = wd_q[FB_DIRTY];
      tw_flg.lock  = wd_q[FB_LOCK];
      tw_flg.lrf   = wd_q[FB_LRF];
    end else if (st == S_LOOK && hit && op_q == OP_STORE) begin
      tw_en        = 1'b1;
      tw_flg.dirty = 1'b1;
      dw_en[hw]    = 1'b1;
      dw_be        = be_st;
      dw_data      = wline_st;
    end else if (fill_wr) begin
      tw_en        = 1'b1;
      tw_way       = vw_q;
      tw_flg.nofr  = ~fo_q;
      tw_flg.valid = 1'b1;
      tw_flg.dirty = 1'b0;
      tw_flg.lock  = rd_flg[vw_q].lock;
      tw_flg.lrf   = ~rd_flg[vw_q].lrf;
      dw_en[vw_q]  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= S_IDLE;
      resp_valid   <= 1'b0;
      resp_rdata   <= '0;
      lock_err     <= 1'b0;
      mem_rd_valid <= 1'b0;
      mem_rd_addr  <= '0;
      mem_wr_valid <= 1'b0;
      mem_wr_addr  <= '0;
      mem_wr_data  <= '0;
      op_q <= '0; sz_q <= '0; a_q <= '0; wd_q <= '0;
      fo_q <= 1'b0; vw_q <= 1'b0; lerr_q <= 1'b0;
    end else begin
      resp_valid <= 1'b0;
      lock_err   <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          op_q <= req_op; sz_q <= req_size; a_q <= req_addr;
          wd_q <= req_wdata; fo_q <= req_frame_ok; lerr_q <= 1'b0;
          st <= S_LOOK;
        end
        S_LOOK: begin
          if (op_q == OP_TAGSET || hit) begin
            resp_valid <= 1'b1;
            lock_err   <= lerr_q;
            if (op_q == OP_LOAD) resp_rdata <= ld_data;
            st <= S_IDLE;
          end else begin
            vw_q   <= vic_way;
            lerr_q <= vic_both;
            if (rd_flg[vic_way].valid && rd_flg[vic_way].dirty && !rd_flg[vic_way].nofr) begin
              mem_wr_valid <= 1'b1;
              mem_wr_addr  <= {rd_tag[vic_way], idx_q, {OFF_W{1'b0}}};
              mem_wr_data  <= rd_line[vic_way];
              st <= S_WB;
            end else begin
              st <= S_FILL;
            end
          end
        end
        S_WB: if (mem_wr_ready) begin
          mem_wr_valid <= 1'b0;
          st <= S_FILL;
        end
        S_FILL: begin
          if (fo_q) begin
            mem_rd_valid <= 1'b1;
            mem_rd_addr  <= {a_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
            st <= S_FREQ;
          end else begin
            st <= S_REREAD;
          end
        end
        S_FREQ: if (mem_rd_ready) begin
          mem_rd_valid <= 1'b0;
          st <= S_FWAIT;
        end
        S_FWAIT:  if (mem_fill_valid) st <= S_REREAD;
        S_REREAD: st <= S_LOOK;
        default:  st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dcache_ctrl_chk.sv
module dcache_ctrl_chk #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 6,
  parameter int LINE_W = 512
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              resp_valid,
  input logic              lock_err,
  input logic              mem_rd_valid,
  input logic              mem_rd_ready,
  input logic [ADDR_W-1:0] mem_rd_addr,
  input logic              mem_wr_valid,
  input logic              mem_wr_ready,
  input logic [ADDR_W-1:0] mem_wr_addr,
  input logic [LINE_W-1:0] mem_wr_data
);
  // R2: fill requests are line aligned
  a_r2_fill_aligned: assert property (@(posedge clk) disable iff (rst)
    mem_rd_valid |-> mem_rd_addr[OFF_W-1:0] == '0);

  // R2: an idle controller raises no memory traffic
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !mem_rd_valid && !mem_wr_valid);

  // R6: writebacks are line aligned
  a_r6_wb_aligned: assert property (@(posedge clk) disable iff (rst)
    mem_wr_valid |-> mem_wr_addr[OFF_W-1:0] == '0);

  // R6: never both requests at once
  a_r6_one_request: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd_valid && mem_wr_valid));

  // R10: fill request held until taken
  a_r10_fill_hold: assert property (@(posedge clk) disable iff (rst)
    mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));

  // R10: writeback request held until taken
  a_r10_wb_hold: assert property (@(posedge clk) disable iff (rst)
    mem_wr_valid && !mem_wr_ready |=>
      mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data));

  // R7: the lock error flag only accompanies a response
  a_r7_err_with_resp: assert property (@(posedge clk) disable iff (rst)
    lock_err |-> resp_valid);
endmodule

bind dcache_ctrl dcache_ctrl_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .LINE_W(LINE_W)) i_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .resp_valid(resp_valid),
  .lock_err(lock_err), .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
  .mem_rd_addr(mem_rd_addr), .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
  .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
);

// File: tb/test_dcache_ctrl.sv
module test_dcache_ctrl;
  localparam int CLK_NS = 10;
  localparam int AW = 32;
  localparam int NS = 4;
  localparam int LW = 512;
  localparam int CW = 128;

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_ready;
  logic [1:0] req_op = 0;
  logic [2:0] req_size = 0;
  logic [AW-1:0] req_addr = 0;
  logic [CW-1:0] req_wdata = 0;
  logic req_frame_ok = 1;
  logic resp_valid, lock_err;
  logic [CW-1:0] resp_rdata;
  logic mem_rd_valid, mem_rd_ready, mem_fill_valid;
  logic [AW-1:0] mem_rd_addr, mem_wr_addr;
  logic [LW-1:0] mem_fill_data, mem_wr_data;
  logic mem_wr_valid, mem_wr_ready;

  always #(CLK_NS/2) clk = ~clk;

  dcache_ctrl #(.ADDR_W(AW), .SETS(NS), .LINE_BYTES(64), .CPU_W(CW)) i_dcache_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_frame_ok(req_frame_ok), .resp_valid(resp_valid), .resp_rdata(resp_rdata),
    .lock_err(lock_err), .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
    .mem_rd_addr(mem_rd_addr), .mem_fill_valid(mem_fill_valid), .mem_fill_data(mem_fill_data),
    .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data)
  );

  function automatic logic [7:0] pat_byte(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h3C;
  endfunction

  function automatic logic [LW-1:0] pat_line(input logic [AW-1:0] la);
    logic [LW-1:0] r;
    for (int b = 0; b < 64; b++) r[b*8 +: 8] = pat_byte(la + AW'(b));
    return r;
  endfunction

  function automatic logic [AW-1:0] la(input int s, input int t);
    return AW'((t << 8) | (s << 6));
  endfunction

  function automatic logic [CW-1:0] exp_load(input logic [AW-1:0] a, input int sz);
    logic [CW-1:0] r = '0;
    for (int b = 0; b < (1 << sz); b++) r[b*8 +: 8] = pat_byte(a + AW'(b));
    return r;
  endfunction

  function automatic logic [CW-1:0] szmask(input int sz);
    logic [CW-1:0] r = '0;
    for (int b = 0; b < (1 << sz); b++) r[b*8 +: 8] = 8'hFF;
    return r;
  endfunction

  // memory model
  int fill_cnt = 0, wb_cnt = 0, seq = 0, fill_seq = 0, wb_seq = 0, pend = 0;
  logic [AW-1:0] last_fill_addr = 0, last_wb_addr = 0;
  logic [LW-1:0] last_wb_data = 0;

  always @(posedge clk) begin
    if (rst) begin
      mem_rd_ready <= 0; mem_wr_ready <= 0; mem_fill_valid <= 0;
      mem_fill_data <= '0; pend <= 0;
    end else begin
      mem_rd_ready <= mem_rd_valid && !mem_rd_ready;
      mem_wr_ready <= mem_wr_valid && !mem_wr_ready;
      mem_fill_valid <= (pend == 1);
      if (pend != 0) pend <= pend - 1;
      if (mem_rd_valid && mem_rd_ready) begin
        fill_cnt <= fill_cnt + 1; last_fill_addr <= mem_rd_addr;
        fill_seq <= seq; seq <= seq + 1; pend <= 2;
        mem_fill_data <= pat_line(mem_rd_addr);
      end
      if (mem_wr_valid && mem_wr_ready) begin
        wb_cnt <= wb_cnt + 1; last_wb_addr <= mem_wr_addr;
        last_wb_data <= mem_wr_data; wb_seq <= seq; seq <= seq + 1;
      end
    end
  end

  int n_chk = 0, n_bad = 0;

  task automatic chk(input string rq, input logic [LW-1:0] act, input logic [LW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  logic [CW-1:0] rd;
  logic le;

  task automatic do_req(input logic [1:0] op, input int sz, input logic [AW-1:0] a,
                        input logic [CW-1:0] wd, input logic fo);
    @(negedge clk);
    req_valid = 1; req_op = op; req_size = 3'(sz); req_addr = a;
    req_wdata = wd; req_frame_ok = fo;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    while (!resp_valid) @(negedge clk);
    rd = resp_rdata; le = lock_err;
  endtask

  function automatic int st_off(input int sz);
    case (sz) 0: return 5; 1: return 10; 2: return 20; 3: return 40; default: return 48; endcase
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int f0, w0;
    logic [LW-1:0] mline;
    logic [CW-1:0] wd;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 req_ready", LW'(req_ready), 1);
    chk("R1 resp_valid", LW'(resp_valid), 0);
    chk("R1 no mem req", LW'({mem_rd_valid, mem_wr_valid}), 0);

    // R2 / R3: miss per set then full size/offset sweep of hits
    for (int s = 0; s < NS; s++) begin
      f0 = fill_cnt;
      do_req(2'd0, 3, la(s, 1) + AW'(s * 16), '0, 1);
      chk("R2 one fill", LW'(fill_cnt - f0), 1);
      chk("R2 fill addr", LW'(last_fill_addr), LW'(la(s, 1)));
      chk("R3 miss load", LW'(rd), LW'(exp_load(la(s, 1) + AW'(s * 16), 3)));
      for (int sz = 0; sz <= 4; sz++)
        for (int off = 0; off < 64; off += (1 << sz)) begin
          do_req(2'd0, sz, la(s, 1) + AW'(off), '0, 1);
          chk("R3 load sweep", LW'(rd), LW'(exp_load(la(s, 1) + AW'(off), sz)));
        end
      chk("R2 hits quiet", LW'(fill_cnt - f0), 1);
    end

    // R4 stores into set 0 line, merged model
    mline = pat_line(la(0, 1));
    for (int sz = 0; sz <= 4; sz++) begin
      wd = {4{32'hC0DE0000 | 32'(sz * 17 + 1)}};
      do_req(2'd1, sz, la(0, 1) + AW'(st_off(sz)), wd, 1);
      for (int b = 0; b < (1 << sz); b++) mline[(st_off(sz) + b) * 8 +: 8] = wd[b*8 +: 8];
    end
    for (int sz = 0; sz <= 4; sz++) begin
      do_req(2'd0, sz, la(0, 1) + AW'(st_off(sz)), '0, 1);
      chk("R4 store readback", LW'(rd), LW'({4{32'hC0DE0000 | 32'(sz * 17 + 1)}} & szmask(sz)));
    end
    do_req(2'd0, 0, la(0, 1), '0, 1);
    chk("R4 untouched byte", LW'(rd), LW'(exp_load(la(0, 1), 0)));

    // R5 / R6 / R1: alternation and writeback order
    w0 = wb_cnt;
    do_req(2'd0, 2, la(0, 2), '0, 1);
    chk("R6 clean victim no wb", LW'(wb_cnt - w0), 0);
    do_req(2'd0, 2, la(0, 3), '0, 1);
    chk("R6 dirty wb", LW'(wb_cnt - w0), 1);
    chk("R1 first fill was way0", LW'(last_wb_addr), LW'(la(0, 1)));
    chk("R4 wb line merged", last_wb_data, mline);
    chk("R6 wb before fill", LW'(wb_seq < fill_seq), 1);
    do_req(2'd1, 2, la(0, 3), 128'h1234, 1);
    w0 = wb_cnt;
    do_req(2'd0, 2, la(0, 4), '0, 1);
    chk("R5 way1 chosen clean", LW'(wb_cnt - w0), 0);
    do_req(2'd0, 2, la(0, 5), '0, 1);
    chk("R5 way0 chosen again", LW'(last_wb_addr), LW'(la(0, 3)));

    // R9 / R7 / R11: locks via tag writes in set 2
    f0 = fill_cnt; w0 = wb_cnt;
    do_req(2'd2, 0, la(2, 0), CW'((32'h30 << 8) | 32'b1010), 1);
    do_req(2'd2, 0, la(2, 0) | 1, CW'((32'h31 << 8) | 32'b1100), 1);
    chk("R9 tag write quiet", LW'({fill_cnt - f0, wb_cnt - w0}), 0);
    do_req(2'd0, 2, la(2, 'h30), '0, 1);
    chk("R9 written tag hits", LW'(fill_cnt - f0), 0);
    do_req(2'd0, 2, la(2, 'h40), '0, 1);
    chk("R7 locked skipped wb addr", LW'(last_wb_addr), LW'(la(2, 'h31)));
    chk("R11 no lock_err", LW'(le), 0);
    chk("R3 load after wb", LW'(rd), LW'(exp_load(la(2, 'h40), 2)));
    do_req(2'd2, 0, la(2, 0) | 1, CW'((32'h32 << 8) | 32'b1110), 1);
    do_req(2'd0, 2, la(2, 'h41), '0, 1);
    chk("R7 both locked err", LW'(le), 1);
    chk("R7 both locked victim", LW'(last_wb_addr), LW'(la(2, 'h32)));
    f0 = fill_cnt;
    do_req(2'd0, 2, la(2, 'h30), '0, 1);
    chk("R7 locked line kept", LW'(fill_cnt - f0), 0);
    chk("R11 hit no lock_err", LW'(le), 0);

    // R8 nonexistent frame in set 3
    f0 = fill_cnt; w0 = wb_cnt;
    do_req(2'd0, 4, la(3, 'h50) + 16, '0, 0);
    chk("R8 no fill req", LW'(fill_cnt - f0), 0);
    chk("R8 zero data", LW'(rd), 0);
    do_req(2'd1, 3, la(3, 'h50) + 8, 128'hFFEE_DDCC_BBAA_9988_7766_5544_3322_1100, 0);
    do_req(2'd0, 3, la(3, 'h50) + 8, '0, 0);
    chk("R8 store readback", LW'(rd), LW'(64'h7766_5544_3322_1100));
    do_req(2'd0, 2, la(3, 'h50), '0, 0);
    chk("R8 rest zero", LW'(rd), 0);
    do_req(2'd0, 2, la(3, 'h51), '0, 1);
    do_req(2'd0, 2, la(3, 'h52), '0, 1);
    chk("R8 dirty eviction dropped", LW'(wb_cnt - w0), 0);
    chk("R8 later fill still made", LW'(fill_cnt - f0), 2);

    summary();
    $finish;
  end
endmodule